// File: doc/BRIEF.md
# Shortened Cyclic Code Parity Encoder

This block accepts a stream of 65-bit words, each a 64-bit payload and one transcode bit, and groups them into codewords of 32 words. It forwards every data word unchanged, one cycle after acceptance. While doing so, it divides the 2080 data bits of the codeword by a fixed degree-32 generator polynomial. After the 32nd word it inserts one extra output beat that carries the 32-bit remainder as parity. The finished codeword is 2112 bits long.

The division is written as a serial shift register with feedback, but it is unrolled so that a whole word is absorbed in one clock. The input is a valid/ready stream. Ready drops for exactly one cycle, while the parity beat is being produced. The output stream has three markers: a valid flag, a start-of-codeword flag on word 0, and a parity flag on the parity beat.

Top module: `fecenc_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, out_valid is 0 and in_ready is 1; the next accepted word is word 0 of a fresh codeword.
- R2: A word accepted (in_valid and in_ready high at a clock edge) appears on the next cycle with out_valid=1, out_parity=0, and out_data and out_tbit equal to the accepted payload and transcode bit.
- R3: out_sop is 1 only on the output beat of word 0 of each codeword and is 0 on all other beats.
- R4: In the cycle after word 31 is accepted, in_ready is 0. The following cycle carries the parity beat: out_valid=1, out_parity=1, out_sop=0, out_tbit=0, out_data[63:32]=0. in_ready is 1 again in that cycle.
- R5: The parity is the remainder of D(x)·x^32 modulo g(x) = x^32+x^23+x^21+x^11+x^2+1, and it appears in out_data[31:0] with bit 31 holding the x^31 coefficient. D(x) is built from the data bits in this order, first bit at the highest power: for each word from 0 to 31, its transcode bit, then payload bit 0 up to payload bit 63.
- R6: The division restarts from zero at every codeword. An all-zero codeword gives zero parity, whatever came before it, including a codeword that was cut short by reset.
- R7: A cycle with in_valid low and in_ready high produces out_valid=0 on the next cycle and does not advance the word position.
- R8: A word offered while in_ready is 0 is not accepted. It produces no output beat and does not enter any codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_tbit | input | 1 | Transcode bit of the input word |
| in_payload | input | 64 | Payload of the input word |
| out_valid | output | 1 | Output beat present |
| out_sop | output | 1 | Beat is word 0 of a codeword |
| out_parity | output | 1 | Beat carries parity |
| out_tbit | output | 1 | Transcode bit of the output beat |
| out_data | output | 64 | Payload, or parity in bits 31:0 |

## Verification
A data word accepted at a clock edge is due on the output one edge later. Its parity beat is due two edges after word 31 is accepted, and in_ready is low in the cycle between those two edges. The bench changes inputs and samples outputs only on the falling edge. At each falling edge it first compares the outputs with the expectation recorded when the previous word was driven, and only then drives the next input. Every result is therefore checked exactly one edge after its cause, with the single-cycle ready gap checked in the cycle it must occur.

// File: rtl/fecenc_pkg.sv
package fecenc_pkg;

    localparam int PAY_W = 64;
    localparam int WORDS = 32;
    localparam int PAR_W = 32;
    // low 32 coefficients of g(x); the x^32 term is implicit
    localparam logic [PAR_W-1:0] GEN_LOW = 32'h00A0_0805;

    typedef struct packed {
        logic             valid;
        logic             sop;
        logic             parity;
        logic             tbit;
        logic [PAY_W-1:0] data;
    } beat_t;

    // one serial division step: shift the remainder, fold in one data bit
    function automatic logic [PAR_W-1:0] div_step(
        input logic [PAR_W-1:0] r,
        input logic             b,
        input logic [PAR_W-1:0] gen
    );
        logic fb;
        fb = r[PAR_W-1] ^ b;
        return {r[PAR_W-2:0], 1'b0} ^ (fb ? gen : '0);
    endfunction

endpackage

// File: rtl/fecenc_divider.sv
module fecenc_divider
    import fecenc_pkg::*;
#(
    parameter int               P_PAY = PAY_W,
    parameter int               P_PAR = PAR_W,
    parameter logic [P_PAR-1:0] P_GEN = GEN_LOW
) (
    input  logic [P_PAR-1:0] rem_in,
    input  logic             tbit,
    input  logic [P_PAY-1:0] payload,
    output logic [P_PAR-1:0] rem_out
);
    localparam int STEPS = P_PAY + 1;

    // bit 0 enters first: transcode bit, then payload LSB upward
    logic [STEPS-1:0] bits_in;
    assign bits_in = {payload, tbit};

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic [P_PAR-1:0] prev;
        logic [P_PAR-1:0] r;
        if (i == 0) begin : g_first
            assign prev = rem_in;
        end else begin : g_next
            assign prev = g_step[i-1].r;
        end
        assign r = div_step(prev, bits_in[i], P_GEN);
    end

    assign rem_out = g_step[STEPS-1].r;
endmodule

// File: rtl/fecenc_seq.sv
module fecenc_seq #(
    parameter int P_WORDS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic first,
    output logic last,
    output logic par_pending
);
    localparam int CW = $clog2(P_WORDS);
    localparam logic [CW-1:0] LAST_IDX = CW'(P_WORDS - 1);

    logic [CW-1:0] cnt;

    assign first = (cnt == '0);
    assign last  = (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            par_pending <= 1'b0;
        end else begin
            if (accept) begin
                cnt <= last ? '0 : cnt + 1'b1;
            end
            par_pending <= accept && last;
        end
    end
endmodule

// File: rtl/fecenc_top.sv
module fecenc_top
    import fecenc_pkg::*;
#(
    parameter int               P_PAY   = PAY_W,
    parameter int               P_WORDS = WORDS,
    parameter int               P_PAR   = PAR_W,
    parameter logic [P_PAR-1:0] P_GEN   = GEN_LOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_tbit,
    input  logic [P_PAY-1:0] in_payload,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_parity,
    output logic             out_tbit,
    output logic [P_PAY-1:0] out_data
);
    localparam int PAD = P_PAY - P_PAR;

    logic             accept, first, last, par_pending;
    logic [P_PAR-1:0] rem_q, rem_start, rem_next;
    beat_t            beat_q;

    assign in_ready = !par_pending;
    assign accept   = in_valid && in_ready;

    fecenc_seq #(.P_WORDS(P_WORDS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .first       (first),
        .last        (last),
        .par_pending (par_pending)
    );

    // clear the division at the start of every codeword
    assign rem_start = first ? '0 : rem_q;

    fecenc_divider #(.P_PAY(P_PAY), .P_PAR(P_PAR), .P_GEN(P_GEN)) u_div (
        .rem_in  (rem_start),
        .tbit    (in_tbit),
        .payload (in_payload),
        .rem_out (rem_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            beat_q <= '0;
        end else begin
            if (accept) begin
                rem_q <= rem_next;
            end
            if (par_pending) begin
                beat_q <= '{valid: 1'b1, sop: 1'b0, parity: 1'b1, tbit: 1'b0,
                            data: {{PAD{1'b0}}, rem_q}};
            end else if (accept) begin
                beat_q <= '{valid: 1'b1, sop: first, parity: 1'b0, tbit: in_tbit,
                            data: in_payload};
            end else begin
                beat_q <= '0;
            end
        end
    end

    assign out_valid  = beat_q.valid;
    assign out_sop    = beat_q.sop;
    assign out_parity = beat_q.parity;
    assign out_tbit   = beat_q.tbit;
    assign out_data   = beat_q.data;

    initial begin
        assert (P_PAY > P_PAR) else $error("payload must be wider than parity");
    end
endmodule

// File: rtl/fecenc_checker.sv
module fecenc_checker #(
    parameter int P_PAY = 64,
    parameter int P_PAR = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_tbit,
    input logic [P_PAY-1:0] in_payload,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_parity,
    input logic             out_tbit,
    input logic [P_PAY-1:0] out_data
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_word_forward_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_parity
            && out_data == $past(in_payload) && out_tbit == $past(in_tbit)));

    assert_sop_on_data_R3: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> (out_valid && !out_parity));

    assert_parity_follows_stall_R4: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (out_valid && out_parity && in_ready));

    assert_parity_format_R4: assert property (@(posedge clk) disable iff (rst)
        out_parity |-> (!out_sop && !out_tbit && out_data[P_PAY-1:P_PAR] == '0));

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && in_ready) |=> !out_valid);

    assert_single_stall_R8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);
endmodule

bind fecenc_top fecenc_checker #(.P_PAY(P_PAY), .P_PAR(P_PAR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_tbit    (in_tbit),
    .in_payload (in_payload),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_parity (out_parity),
    .out_tbit   (out_tbit),
    .out_data   (out_data)
);

// File: tb/fecenc_top_bench.sv
module fecenc_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_tbit = 1'b0;
    logic [63:0] in_payload = '0;
    logic        in_ready, out_valid, out_sop, out_parity, out_tbit;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fecenc_top u_fecenc_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tbit(in_tbit), .in_payload(in_payload), .out_valid(out_valid),
        .out_sop(out_sop), .out_parity(out_parity), .out_tbit(out_tbit),
        .out_data(out_data)
    );

    // stimulus table: payload seed, transcode mask, idle-before-word mask
    localparam int NPAT = 5;
    localparam logic [63:0] T_SEED [NPAT] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                             64'h0123_4567_89AB_CDEF, 64'hA5A5_0F0F_3C3C_9669};
    localparam logic [31:0] T_TMSK [NPAT] = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0001,
                                             32'h8421_7E5A, 32'h0F0F_3311};
    localparam logic [31:0] T_GAP  [NPAT] = '{32'h0, 32'h0, 32'h8000_0002,
                                             32'h0001_0010, 32'h0};

    function automatic logic [63:0] pay(input logic [63:0] seed, input int w);
        if (seed == 64'h0) return 64'h0;
        if (seed == '1) return '1;
        return seed ^ (64'h9E37_79B9_7F4A_7C15 * 64'(w + 1));
    endfunction

    // bit-serial reference division in the order stated in R5
    function automatic logic [31:0] ref_parity(input logic [63:0] seed, input logic [31:0] tm);
        logic [31:0] r = '0;
        for (int w = 0; w < 32; w++) begin
            logic [64:0] bits = {pay(seed, w), tm[w]};
            for (int k = 0; k < 65; k++) begin
                logic fb = r[31] ^ bits[k];
                r = r << 1;
                if (fb) r = r ^ 32'h00A0_0805;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expectation for the beat due at the next falling edge
    int          e_kind = 0;   // 0 idle, 1 data word, 2 parity
    logic [63:0] e_data;
    logic        e_t, e_sop;

    task automatic check_due();
        if (e_kind == 0) begin
            chk(!out_valid, "R7", 64'(out_valid), 64'd0);
        end else if (e_kind == 1) begin
            chk(out_valid && !out_parity && out_data == e_data && out_tbit == e_t,
                "R2", out_data, e_data);
            chk(out_sop == e_sop, "R3", 64'(out_sop), 64'(e_sop));
        end else begin
            chk(out_valid && out_parity && !out_sop && !out_tbit && out_data[63:32] == 32'h0,
                "R4", {out_valid, out_parity, out_sop, out_tbit}, 64'b1100);
            chk(out_data[31:0] == e_data[31:0], "R5", out_data, e_data);
        end
    endtask

    task automatic run_cw(input logic [63:0] seed, input logic [31:0] tm, input logic [31:0] gap);
        logic [31:0] par = ref_parity(seed, tm);
        for (int w = 0; w < 32; w++) begin
            if (gap[w]) begin
                @(negedge clk);
                check_due();
                in_valid = 1'b0;
                e_kind = 0;
            end
            @(negedge clk);
            check_due();
            chk(in_ready, "R4", 64'(in_ready), 64'd1);
            in_valid = 1'b1; in_payload = pay(seed, w); in_tbit = tm[w];
            e_kind = 1; e_data = in_payload; e_t = in_tbit; e_sop = (w == 0);
        end
        @(negedge clk);
        check_due();
        chk(!in_ready, "R4", 64'(in_ready), 64'd0);
        // R8: offer a word while ready is low
        in_valid = 1'b1; in_payload = 64'hDEAD_BEEF_0BAD_F00D; in_tbit = 1'b1;
        e_kind = 2; e_data = {32'h0, par};
        @(negedge clk);
        check_due();
        if (seed == 64'h0 && tm == 32'h0)
            chk(out_data == 64'h0, "R6", out_data, 64'h0);
        chk(in_ready, "R4", 64'(in_ready), 64'd1);
        in_valid = 1'b0;
        e_kind = 0;
        @(negedge clk);
        chk(!out_valid, "R8", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 64'b01);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 64'b01);
        e_kind = 0;

        for (int p = 0; p < NPAT; p++) run_cw(T_SEED[p], T_TMSK[p], T_GAP[p]);

        // two back-to-back codewords: second starts clean (R6)
        run_cw(64'h0, 32'h0, 32'h0);

        // reset partway through a codeword, then a zero codeword
        for (int w = 0; w < 5; w++) begin
            @(negedge clk);
            in_valid = 1'b1; in_payload = pay(64'h1357_9BDF_2468_ACE0, w); in_tbit = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 64'b01);
        e_kind = 0;
        run_cw(64'h0, 32'h0, 32'h0);   // R6 after reset cut-off
        run_cw(T_SEED[3], T_TMSK[3], 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule